// File: doc/BRIEF.md
# Stream Compaction Scatter Unit

This block filters a stream of items down to the ones whose keep flag is set. The items arrive several at a time on a valid/ready stream. Each accepted item gets an exclusive prefix count of the keep flags. That count is the number of flagged items seen earlier in the same packet, and it becomes the item's write address in a memory. Only flagged items produce a write. When the last beat of a packet has been consumed, a one-cycle done pulse reports how many items were kept.

The writes go back into the buffer the items were read from. This is safe because an item's target address never exceeds its own index in the packet, so a write cannot overwrite an item that has not yet been read. The keep decision is made once per item, in the same pass that computes the address, so every item is read exactly once. A hold input from the memory side stalls the stream. While the stream is stalled, or while no beat is offered, nothing inside the block changes.

Top module: `scmp_compactor`

## Requirements
- R1: After reset, `wr_en` is all zero, `done` is 0, `kept_count` is 0, and `in_ready` is 1 while `wr_hold` is low.
- R2: A beat is consumed when `in_valid` and `in_ready` are both high at a rising edge. In the cycle that follows, lane j drives a write (`wr_en[j]`=1, data from `in_data[j*DW +: DW]`) exactly when `in_keep[j]` was 1. Unflagged lanes drive no write, and no write appears in a cycle that does not follow a consumed beat.
- R3: The write address of a kept item equals the number of kept items that precede it in the packet. Within a beat, lane 0 counts as the earliest item. The count carries across beats.
- R4: A kept item's write address is never larger than the item's own index in the packet (index 0 is lane 0 of the first beat), and it is always below the number of items read so far.
- R5: In the cycle after the beat with `in_last`=1 is consumed, `done` is high for one cycle and `kept_count` equals the packet's total of keep flags. `kept_count` changes only in a cycle where `done` is high.
- R6: The first kept item after a packet ends is written to address 0.
- R7: While `wr_hold` is 1, `in_ready` is 0. An offered beat is not consumed, no write occurs, and the running count is left unchanged.
- R8: Cycles with `in_valid`=0 between beats produce no writes and leave the running count unchanged.
- R9: A packet with no keep flags set produces no writes and a done pulse with `kept_count` 0.
- R10: When every item of a packet is kept, each item's write address equals its own index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A beat of LANES items is offered |
| in_ready | output | 1 | The block can consume the offered beat |
| in_data | input | LANES*DW | Item payloads, lane j at bits j*DW upward |
| in_keep | input | LANES | Keep flag per lane |
| in_last | input | 1 | The beat closes the packet |
| wr_hold | input | 1 | Memory side cannot take writes; stalls the stream |
| wr_en | output | LANES | Write enable per lane |
| wr_addr | output | LANES*AW | Write address per lane, lane j at bits j*AW upward |
| wr_data | output | LANES*DW | Write data per lane |
| done | output | 1 | One-cycle pulse after the last beat |
| kept_count | output | AW+1 | Number of items kept in the last finished packet |

## Verification
Every result is due one cycle after the edge that consumes a beat. The writes of that beat, and the done pulse if the beat closed the packet, appear together at the next rising edge. The bench drives inputs just after a rising edge and samples all outputs on the falling edge, which lands halfway into the cycle where these results are valid. A scoreboard predicts, from the keep patterns alone, the address, data and packet index of every write, plus every done count, in order. Any write or done pulse that arrives without a matching prediction fails, and so does a prediction still left over at the end. This ordering also catches writes leaking out of hold and idle cycles.

// File: rtl/scmp_pkg.sv
package scmp_pkg;

   // Variant of the per-beat flag scan
   typedef enum logic {
      SCAN_RIPPLE = 1'b0,
      SCAN_LOG    = 1'b1
   } scan_style_e;

   // Bits needed to hold a count from 0 to n
   function automatic int count_bits(input int n);
      return (n < 1) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/scmp_lane_scan.sv
module scmp_lane_scan #(
   parameter int                    LANES = 4,
   parameter int                    SW    = 3,
   parameter scmp_pkg::scan_style_e STYLE = scmp_pkg::SCAN_LOG
) (
   input  logic [LANES-1:0]         flag,
   output logic [LANES-1:0][SW-1:0] excl,
   output logic [SW-1:0]            total
);

   localparam int STAGES = (LANES > 1) ? $clog2(LANES) : 1;

   if (SW < scmp_pkg::count_bits(LANES)) begin : g_bad_sw
      $error("scmp_lane_scan: SW too narrow for LANES");
   end

   if (STYLE == scmp_pkg::SCAN_RIPPLE) begin : g_ripple
      always_comb begin
         logic [SW-1:0] acc;
         acc = '0;
         for (int j = 0; j < LANES; j++) begin
            excl[j] = acc;
            acc     = acc + SW'(flag[j]);
         end
         total = acc;
      end
   end else begin : g_log
      // log-depth doubling over inclusive counts, then shift by one lane
      always_comb begin
         logic [LANES-1:0][SW-1:0] cur;
         logic [LANES-1:0][SW-1:0] nxt;
         for (int j = 0; j < LANES; j++) cur[j] = SW'(flag[j]);
         for (int s = 0; s < STAGES; s++) begin
            for (int j = 0; j < LANES; j++) begin
               if (j >= (1 << s)) nxt[j] = cur[j] + cur[j - (1 << s)];
               else               nxt[j] = cur[j];
            end
            cur = nxt;
         end
         excl[0] = '0;
         for (int j = 1; j < LANES; j++) excl[j] = cur[j-1];
         total = cur[LANES-1];
      end
   end

endmodule

// File: rtl/scmp_scatter_reg.sv
module scmp_scatter_reg #(
   parameter int LANES = 4,
   parameter int DW    = 16,
   parameter int AW    = 10,
   parameter int SW    = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     fire,
   input  logic [LANES-1:0]         keep,
   input  logic [LANES*DW-1:0]      data,
   input  logic [AW-1:0]            base,
   input  logic [LANES-1:0][SW-1:0] excl,
   output logic [LANES-1:0]         wr_en,
   output logic [LANES*AW-1:0]      wr_addr,
   output logic [LANES*DW-1:0]      wr_data
);

   if (AW < SW) begin : g_bad_aw
      $error("scmp_scatter_reg: AW narrower than lane count");
   end

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      logic [AW-1:0] tgt;
      assign tgt = base + AW'(excl[j]);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            wr_en[j]               <= 1'b0;
            wr_addr[j*AW +: AW]    <= '0;
            wr_data[j*DW +: DW]    <= '0;
         end else begin
            wr_en[j] <= fire & keep[j];
            if (fire) begin
               wr_addr[j*AW +: AW] <= tgt;
               wr_data[j*DW +: DW] <= data[j*DW +: DW];
            end
         end
      end
   end

endmodule

// File: rtl/scmp_compactor.sv
module scmp_compactor #(
   parameter int                    LANES = 4,
   parameter int                    DW    = 16,
   parameter int                    AW    = 10,
   parameter scmp_pkg::scan_style_e STYLE = scmp_pkg::SCAN_LOG
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [LANES*DW-1:0] in_data,
   input  logic [LANES-1:0]    in_keep,
   input  logic                in_last,
   input  logic                wr_hold,
   output logic [LANES-1:0]    wr_en,
   output logic [LANES*AW-1:0] wr_addr,
   output logic [LANES*DW-1:0] wr_data,
   output logic                done,
   output logic [AW:0]         kept_count
);

   localparam int SW = scmp_pkg::count_bits(LANES);
   localparam int CW = AW + 1;

   if (LANES < 1 || DW < 1 || AW < 1) begin : g_bad_param
      $error("scmp_compactor: LANES, DW and AW must be positive");
   end

   logic                     fire;
   logic [LANES-1:0][SW-1:0] excl;
   logic [SW-1:0]            beat_total;
   logic [CW-1:0]            base_q;
   logic [CW-1:0]            base_next;

   assign in_ready  = ~wr_hold;
   assign fire      = in_valid & in_ready;
   assign base_next = base_q + CW'(beat_total);

   scmp_lane_scan #(
      .LANES (LANES),
      .SW    (SW),
      .STYLE (STYLE)
   ) u_scan (
      .flag  (in_keep),
      .excl  (excl),
      .total (beat_total)
   );

   scmp_scatter_reg #(
      .LANES (LANES),
      .DW    (DW),
      .AW    (AW),
      .SW    (SW)
   ) u_scatter (
      .clk     (clk),
      .rst_n   (rst_n),
      .fire    (fire),
      .keep    (in_keep),
      .data    (in_data),
      .base    (base_q[AW-1:0]),
      .excl    (excl),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q     <= '0;
         done       <= 1'b0;
         kept_count <= '0;
      end else begin
         done <= fire & in_last;
         if (fire) begin
            base_q <= in_last ? '0 : base_next;
            if (in_last) kept_count <= base_next;
         end
      end
   end

endmodule

// File: rtl/scmp_compactor_chk.sv
module scmp_compactor_chk #(
   parameter int LANES = 4,
   parameter int DW    = 16,
   parameter int AW    = 10
) (
   input logic                clk,
   input logic                rst_n,
   input logic                in_valid,
   input logic                in_ready,
   input logic                in_last,
   input logic                wr_hold,
   input logic [LANES-1:0]    wr_en,
   input logic [LANES*AW-1:0] wr_addr,
   input logic                done,
   input logic [AW:0]         kept_count
);

   localparam int CW = AW + 1;

   logic          fire_q;
   logic          last_q;
   logic [AW:0]   kc_q;
   logic [CW-1:0] rd_base;
   logic [CW-1:0] rd_seen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fire_q  <= 1'b0;
         last_q  <= 1'b0;
         kc_q    <= '0;
         rd_base <= '0;
         rd_seen <= '0;
      end else begin
         fire_q <= in_valid & in_ready;
         last_q <= in_valid & in_ready & in_last;
         kc_q   <= kept_count;
         if (in_valid & in_ready) begin
            rd_seen <= rd_base + CW'(LANES);
            rd_base <= in_last ? '0 : rd_base + CW'(LANES);
         end
      end
   end

   // R2
   wr_after_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en != '0) |-> fire_q);

   // R5
   done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> last_q);

   // R5
   count_only_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kept_count != kc_q) |-> done);

   // R7
   hold_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hold |-> !in_ready);

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      // R4
      in_place_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
         wr_en[j] |-> (CW'(wr_addr[j*AW +: AW]) < rd_seen));
      if (j > 0) begin : g_pair
         // R3
         dense_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en[j] && wr_en[j-1]) |->
            (wr_addr[j*AW +: AW] == wr_addr[(j-1)*AW +: AW] + AW'(1)));
      end
   end

endmodule

bind scmp_compactor scmp_compactor_chk #(
   .LANES (LANES),
   .DW    (DW),
   .AW    (AW)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_ready   (in_ready),
   .in_last    (in_last),
   .wr_hold    (wr_hold),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .done       (done),
   .kept_count (kept_count)
);

// File: tb/scmp_compactor_bench.sv
`timescale 1ns/1ps
module scmp_compactor_bench;

   localparam int LANES = 4;
   localparam int DW    = 16;
   localparam int AW    = 10;

   typedef struct {
      int    addr;
      int    data;
      int    idx;
      string tag;
   } wr_exp_t;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                in_valid = 1'b0;
   logic                in_ready;
   logic [LANES*DW-1:0] in_data = '0;
   logic [LANES-1:0]    in_keep = '0;
   logic                in_last = 1'b0;
   logic                wr_hold = 1'b0;
   logic [LANES-1:0]    wr_en;
   logic [LANES*AW-1:0] wr_addr;
   logic [LANES*DW-1:0] wr_data;
   logic                done;
   logic [AW:0]         kept_count;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   wr_exp_t wq[$];
   int      dq[$];

   int exp_base = 0;
   int item_idx = 0;
   int pkt_id   = 0;

   always #2.5 clk = ~clk;

   scmp_compactor u_scmp_compactor (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_ready   (in_ready),
      .in_data    (in_data),
      .in_keep    (in_keep),
      .in_last    (in_last),
      .wr_hold    (wr_hold),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .done       (done),
      .kept_count (kept_count)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // driver: offer one beat, predict its writes and done count
   task automatic send_beat(input logic [LANES-1:0] keep, input bit last, input string tag);
      for (int j = 0; j < LANES; j++) begin
         int d;
         d = ((pkt_id * 97 + item_idx * 13 + 5) & 16'hFFFF);
         in_data[j*DW +: DW] = DW'(d);
         if (keep[j]) begin
            wr_exp_t e;
            e.addr = exp_base; e.data = d; e.idx = item_idx; e.tag = tag;
            wq.push_back(e);
            exp_base++;
         end
         item_idx++;
      end
      in_keep  = keep;
      in_last  = last;
      in_valid = 1'b1;
      if (last) begin
         dq.push_back(exp_base);
         exp_base = 0;
         item_idx = 0;
         pkt_id++;
      end
      @(posedge clk); #1;
      in_valid = 1'b0;
      in_last  = 1'b0;
      in_keep  = '0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   // R7: offer a fully kept closing beat while held; it must be ignored
   task automatic held_beat(input int n);
      wr_hold  = 1'b1;
      in_valid = 1'b1;
      in_keep  = '1;
      in_last  = 1'b1;
      in_data  = '1;
      repeat (n) begin
         @(negedge clk);
         chk(in_ready == 1'b0, "R7 in_ready during hold", int'(in_ready), 0);
      end
      @(posedge clk); #1;
      in_valid = 1'b0;
      in_last  = 1'b0;
      in_keep  = '0;
      wr_hold  = 1'b0;
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         for (int j = 0; j < LANES; j++) begin
            if (wr_en[j]) begin
               if (wq.size() == 0) begin
                  chk(1'b0, "R2 unexpected write lane", j, -1);
               end else begin
                  wr_exp_t e;
                  int a;
                  e = wq.pop_front();
                  a = int'(wr_addr[j*AW +: AW]);
                  chk(a == e.addr, {e.tag, " R3 address"}, a, e.addr);
                  chk(int'(wr_data[j*DW +: DW]) == e.data, "R2 data", int'(wr_data[j*DW +: DW]), e.data);
                  chk(a <= e.idx, "R4 address within read range", a, e.idx);
               end
            end
         end
         if (done) begin
            if (dq.size() == 0) begin
               chk(1'b0, "R5 unexpected done", int'(kept_count), -1);
            end else begin
               int k;
               k = dq.pop_front();
               chk(int'(kept_count) == k, "R5 kept_count", int'(kept_count), k);
            end
         end
      end
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         finished = 1;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk(wr_en == '0, "R1 wr_en", int'(wr_en), 0);
      chk(done == 1'b0, "R1 done", int'(done), 0);
      chk(kept_count == '0, "R1 kept_count", int'(kept_count), 0);
      chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
      @(posedge clk); #1;

      // R2 R3: mixed flags over three beats
      send_beat(4'b1011, 0, "R3");
      send_beat(4'b0110, 0, "R3");
      send_beat(4'b1111, 1, "R3");

      // R8: idle gaps inside a packet
      send_beat(4'b0000, 0, "R8");
      idle(3);
      send_beat(4'b1000, 0, "R8");
      idle(2);
      send_beat(4'b0011, 1, "R8");

      // R10: all kept
      send_beat(4'b1111, 0, "R10");
      send_beat(4'b1111, 1, "R10");

      // R9: nothing kept
      send_beat(4'b0000, 0, "R9");
      send_beat(4'b0000, 1, "R9");

      // R7: hold in the middle of a packet
      send_beat(4'b0101, 0, "R7");
      held_beat(4);
      idle(1);
      send_beat(4'b1100, 1, "R7");

      // R6: back-to-back single-beat packets restart at 0
      send_beat(4'b0100, 1, "R6");
      send_beat(4'b0010, 1, "R6");
      send_beat(4'b1001, 1, "R6");

      // long packet with a varying pattern
      for (int i = 0; i < 40; i++) begin
         send_beat(4'((i * 7 + 3) % 16), (i == 39), "R3");
         if (i % 9 == 4) idle(1);
      end

      idle(4);
      // R5: every predicted write and done was observed
      chk(wq.size() == 0, "R2 pending writes", wq.size(), 0);
      chk(dq.size() == 0, "R5 pending done", dq.size(), 0);

      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule